// File: doc/BRIEF.md
# Receive Packet Status Tracker

This block does the per-packet bookkeeping for the receive side of a byte FIFO. A MAC-side writer marks the start of a frame, each byte it stores and the end of the frame, and it gives a short kind code for the frame at the end. The block keeps a circular queue of descriptors, one for each frame held. Each descriptor holds the stored length, how many bytes the host has read, whether the frame is complete, and the encoded error class. The FIFO storage is modelled only as a byte occupancy counter of configurable capacity.

The host sees a 16-bit status word that describes the packet at the head of the queue. It can read bytes of that packet one at a time and can drop the whole head packet with a discard strobe. The block also drives diagnostic flags: receiving, descriptor queue full (status overrun), byte FIFO full (byte overrun) and read underrun. A read underrun raises adapter failure and stays latched until a receive reset.

The block is built from three state machines. The writer has three states. W_IDLE moves to W_RECV on an accepted start. W_RECV goes back to W_IDLE on an end, and goes to W_CLIP when a byte arrives while the FIFO is halted. W_CLIP goes back to W_IDLE on an end. The occupancy tracker has two states: O_FLOW moves to O_HALT when occupancy reaches capacity, and O_HALT returns to O_FLOW once occupancy has fallen by the release margin. The host port has two states: H_RUN moves to H_FAULT on a bad read, and only a reset leaves H_FAULT.

Top module: `rx_pkt_tracker`

## Requirements
- R1: With no packet queued, rx_status reads 0x8000. While the head packet is still being written, bit 15 is 1, bits 14..11 are 0, and bits 10..0 give the bytes stored so far.
- R2: A completed head packet shows bit 15 = 0 and bits 10..0 = its length. mac_kind 0 (good) gives bit 14 = 0 with code 000 in bits 13..11. mac_kind 1 (dribble) gives bit 14 = 0 with code 010.
- R3: mac_kind 2 (runt), 3 (alignment) and 4 (CRC) give bit 14 = 1 with codes 011, 100 and 101 in bits 13..11. Values 5 to 7 are treated as good.
- R4: A frame with more than 1514 bytes is reported with bit 14 = 1, code 001 and length 1514. Bytes beyond 1514 are not stored.
- R5: flag_stat_ovr is high while 8 packets are queued. A start seen while it is high is refused, and the whole frame is dropped. The flag clears once a packet is discarded.
- R6: flag_byte_ovr sets when occupancy reaches capacity. While it is set, bytes are dropped and starts are refused. A frame that loses bytes this way is reported with bit 14 = 1 and code 000. The flag clears when occupancy falls to capacity minus 4.
- R7: A host read when the queue is empty, or when every stored byte of the head has been read, sets flag_underrun and adapter_fail. Both stay set through later reads and discards. Reading exactly the stored length does not set them.
- R8: flag_receiving is high from the cycle after an accepted start until the cycle after its end.
- R9: host_discard removes a completed head packet and all of its unread bytes. It is ignored when the queue is empty or the head is incomplete. A host_rd in the same cycle as host_discard is ignored.
- R10: rx_complete pulses for one cycle when a completed packet first appears at the head, either because its end was written or because the packet ahead of it was discarded.
- R11: rx_reset, and rst_n low, empty the queue and the occupancy and clear every flag, including underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive-side reset |
| mac_start | input | 1 | Frame start strobe |
| mac_byte | input | 1 | One byte stored strobe |
| mac_end | input | 1 | Frame end strobe |
| mac_kind | input | 3 | Frame kind, sampled with mac_end |
| host_rd | input | 1 | Read one byte of the head packet |
| host_discard | input | 1 | Drop the head packet |
| rx_status | output | 16 | Head packet status word |
| rx_complete | output | 1 | Completed packet newly at head |
| flag_receiving | output | 1 | Frame being written |
| flag_stat_ovr | output | 1 | Descriptor queue full |
| flag_byte_ovr | output | 1 | Byte FIFO full, reception halted |
| flag_underrun | output | 1 | Read past stored data |
| adapter_fail | output | 1 | Latched failure from underrun |

## Verification
The assertions take for granted that mac_start, mac_byte and mac_end are never high together. They also assume that mac_start arrives only while no frame is open, and that bytes and ends follow an accepted or refused start. The bench keeps to this by driving every MAC event through one task that raises a single strobe per cycle and always closes a frame with an end. Host strobes may coincide with each other and are exercised together on purpose.

// File: rtl/rx_trk_pkg.sv
package rx_trk_pkg;

    localparam logic [2:0] CODE_OVERRUN  = 3'b000;
    localparam logic [2:0] CODE_OVERSIZE = 3'b001;
    localparam logic [2:0] CODE_DRIBBLE  = 3'b010;
    localparam logic [2:0] CODE_RUNT     = 3'b011;
    localparam logic [2:0] CODE_ALIGN    = 3'b100;
    localparam logic [2:0] CODE_CRC      = 3'b101;
    localparam logic [2:0] CODE_NONE     = 3'b000;

    typedef enum logic [1:0] {W_IDLE, W_RECV, W_CLIP} wr_state_e;
    typedef enum logic {O_FLOW, O_HALT} occ_state_e;
    typedef enum logic {H_RUN, H_FAULT} host_state_e;

    // {error, code} for a frame that ended normally
    function automatic logic [3:0] kind_to_class(input logic [2:0] kind);
        logic [3:0] r;
        unique case (kind)
            3'd1:    r = {1'b0, CODE_DRIBBLE};
            3'd2:    r = {1'b1, CODE_RUNT};
            3'd3:    r = {1'b1, CODE_ALIGN};
            3'd4:    r = {1'b1, CODE_CRC};
            default: r = {1'b0, CODE_NONE};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx_write_fsm.sv
module rx_write_fsm
    import rx_trk_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MAX_LEN = 1514
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       mac_start,
    input  logic       mac_byte,
    input  logic       mac_end,
    input  logic [2:0] mac_kind,
    input  logic       q_full,
    input  logic       byte_halt,
    output logic       alloc,
    output logic       store,
    output logic       fin,
    output logic       fin_err,
    output logic [2:0] fin_code,
    output logic       receiving
);

    wr_state_e        state_q, state_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             over_q, over_d;
    logic [3:0]       cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            len_q   <= '0;
            over_q  <= 1'b0;
        end else if (clr) begin
            state_q <= W_IDLE;
            len_q   <= '0;
            over_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            over_q  <= over_d;
        end
    end

    assign cls = kind_to_class(mac_kind);

    always_comb begin
        state_d  = state_q;
        len_d    = len_q;
        over_d   = over_q;
        alloc    = 1'b0;
        store    = 1'b0;
        fin      = 1'b0;
        fin_err  = 1'b0;
        fin_code = CODE_NONE;
        unique case (state_q)
            W_IDLE: begin
                if (mac_start && !q_full && !byte_halt) begin
                    alloc   = 1'b1;
                    len_d   = '0;
                    over_d  = 1'b0;
                    state_d = W_RECV;
                end
            end
            W_RECV: begin
                if (mac_byte) begin
                    if (byte_halt) begin
                        state_d = W_CLIP;
                    end else if (len_q == LEN_W'(MAX_LEN)) begin
                        over_d = 1'b1;
                    end else begin
                        store = 1'b1;
                        len_d = len_q + 1'b1;
                    end
                end else if (mac_end) begin
                    fin     = 1'b1;
                    state_d = W_IDLE;
                    if (over_q) begin
                        fin_err  = 1'b1;
                        fin_code = CODE_OVERSIZE;
                    end else begin
                        fin_err  = cls[3];
                        fin_code = cls[2:0];
                    end
                end
            end
            W_CLIP: begin
                if (mac_end) begin
                    fin      = 1'b1;
                    fin_err  = 1'b1;
                    fin_code = CODE_OVERRUN;
                    state_d  = W_IDLE;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    assign receiving = (state_q != W_IDLE);

endmodule

// File: rtl/rx_desc_queue.sv
module rx_desc_queue #(
    parameter int DEPTH = 8,
    parameter int LEN_W = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             alloc,
    input  logic             store,
    input  logic             fin,
    input  logic             fin_err,
    input  logic [2:0]       fin_code,
    input  logic             rd_inc,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic [LEN_W-1:0] head_len,
    output logic [LEN_W-1:0] head_rd,
    output logic             head_done,
    output logic             head_err,
    output logic [2:0]       head_code
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] head_q, tail_q, cur_q;
    logic [LEN_W-1:0] len_m  [DEPTH];
    logic [LEN_W-1:0] rd_m   [DEPTH];
    logic [2:0]       code_m [DEPTH];
    logic [DEPTH-1:0] done_m, err_m;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cur_q  <= '0;
            count  <= '0;
        end else if (clr) begin
            head_q <= '0;
            tail_q <= '0;
            cur_q  <= '0;
            count  <= '0;
        end else begin
            if (alloc) begin
                cur_q  <= tail_q;
                tail_q <= bump(tail_q);
            end
            if (pop) head_q <= bump(head_q);
            count <= count + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    // descriptor storage: every field is initialised on allocation
    always_ff @(posedge clk) begin
        if (alloc) begin
            len_m[tail_q]  <= '0;
            rd_m[tail_q]   <= '0;
            code_m[tail_q] <= '0;
            done_m[tail_q] <= 1'b0;
            err_m[tail_q]  <= 1'b0;
        end
        if (store) len_m[cur_q] <= len_m[cur_q] + 1'b1;
        if (fin) begin
            done_m[cur_q] <= 1'b1;
            err_m[cur_q]  <= fin_err;
            code_m[cur_q] <= fin_code;
        end
        if (rd_inc) rd_m[head_q] <= rd_m[head_q] + 1'b1;
    end

    assign head_len  = len_m[head_q];
    assign head_rd   = rd_m[head_q];
    assign head_done = done_m[head_q];
    assign head_err  = err_m[head_q];
    assign head_code = code_m[head_q];

endmodule

// File: rtl/rx_byte_occ.sv
module rx_byte_occ
    import rx_trk_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    parameter int RELEASE    = 4,
    parameter int LEN_W      = 11,
    parameter int OCC_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec_one,
    input  logic             dec_pkt,
    input  logic [LEN_W-1:0] pkt_bytes,
    output logic [OCC_W-1:0] occ,
    output logic             halt
);

    occ_state_e       state_q, state_d;
    logic [OCC_W-1:0] occ_d;

    always_comb begin
        occ_d = occ + OCC_W'(inc) - OCC_W'(dec_one)
                - (dec_pkt ? OCC_W'(pkt_bytes) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= O_FLOW;
            occ     <= '0;
        end else if (clr) begin
            state_q <= O_FLOW;
            occ     <= '0;
        end else begin
            state_q <= state_d;
            occ     <= occ_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            O_FLOW: if (occ_d == OCC_W'(FIFO_BYTES)) state_d = O_HALT;
            O_HALT: if (occ_d <= OCC_W'(FIFO_BYTES - RELEASE)) state_d = O_FLOW;
            default: state_d = O_FLOW;
        endcase
    end

    assign halt = (state_q == O_HALT);

endmodule

// File: rtl/rx_host_port.sv
module rx_host_port
    import rx_trk_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             host_rd,
    input  logic             host_discard,
    input  logic             q_empty,
    input  logic             head_done,
    input  logic [LEN_W-1:0] head_len,
    input  logic [LEN_W-1:0] head_rd,
    output logic             rd_ok,
    output logic             pop,
    output logic [LEN_W-1:0] pop_bytes,
    output logic             fault
);

    host_state_e state_q, state_d;
    logic        want_rd, avail, bad_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= H_RUN;
        else if (clr) state_q <= H_RUN;
        else          state_q <= state_d;
    end

    always_comb begin
        want_rd   = host_rd && !host_discard;
        avail     = !q_empty && (head_rd != head_len);
        rd_ok     = want_rd && avail;
        bad_rd    = want_rd && !avail;
        pop       = host_discard && !q_empty && head_done;
        pop_bytes = head_len - head_rd;
        state_d   = state_q;
        unique case (state_q)
            H_RUN:   if (bad_rd) state_d = H_FAULT;
            H_FAULT: state_d = H_FAULT;
            default: state_d = H_RUN;
        endcase
    end

    assign fault = (state_q == H_FAULT);

endmodule

// File: rtl/rx_pkt_tracker.sv
module rx_pkt_tracker
    import rx_trk_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int FIFO_BYTES = 2048,
    parameter int MAX_LEN    = 1514,
    parameter int RELEASE    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_reset,
    input  logic        mac_start,
    input  logic        mac_byte,
    input  logic        mac_end,
    input  logic [2:0]  mac_kind,
    input  logic        host_rd,
    input  logic        host_discard,
    output logic [15:0] rx_status,
    output logic        rx_complete,
    output logic        flag_receiving,
    output logic        flag_stat_ovr,
    output logic        flag_byte_ovr,
    output logic        flag_underrun,
    output logic        adapter_fail
);

    localparam int LEN_W = 11;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OCC_W = $clog2(FIFO_BYTES + 1);

    logic             alloc, store, fin, fin_err;
    logic [2:0]       fin_code;
    logic             rd_ok, pop, fault, halt;
    logic [CNT_W-1:0] q_count;
    logic [OCC_W-1:0] occ;
    logic [LEN_W-1:0] head_len, head_rd, pop_bytes;
    logic             head_done, head_err, q_empty, q_full;
    logic [2:0]       head_code;
    logic             head_vis, vis_d, pop_d;

    assign q_empty = (q_count == '0);
    assign q_full  = (q_count == CNT_W'(DEPTH));

    rx_write_fsm #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end),
        .mac_kind(mac_kind), .q_full(q_full), .byte_halt(halt),
        .alloc(alloc), .store(store), .fin(fin), .fin_err(fin_err),
        .fin_code(fin_code), .receiving(flag_receiving)
    );

    rx_desc_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_q (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .alloc(alloc), .store(store), .fin(fin), .fin_err(fin_err),
        .fin_code(fin_code), .rd_inc(rd_ok), .pop(pop), .count(q_count),
        .head_len(head_len), .head_rd(head_rd), .head_done(head_done),
        .head_err(head_err), .head_code(head_code)
    );

    rx_byte_occ #(.FIFO_BYTES(FIFO_BYTES), .RELEASE(RELEASE),
                  .LEN_W(LEN_W), .OCC_W(OCC_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .inc(store), .dec_one(rd_ok), .dec_pkt(pop), .pkt_bytes(pop_bytes),
        .occ(occ), .halt(halt)
    );

    rx_host_port #(.LEN_W(LEN_W)) u_host (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .host_rd(host_rd), .host_discard(host_discard), .q_empty(q_empty),
        .head_done(head_done), .head_len(head_len), .head_rd(head_rd),
        .rd_ok(rd_ok), .pop(pop), .pop_bytes(pop_bytes), .fault(fault)
    );

    // head visibility history drives the completion pulse
    assign head_vis = !q_empty && head_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_d <= 1'b0;
            pop_d <= 1'b0;
        end else if (rx_reset) begin
            vis_d <= 1'b0;
            pop_d <= 1'b0;
        end else begin
            vis_d <= head_vis;
            pop_d <= pop;
        end
    end

    always_comb begin
        if (q_empty)         rx_status = 16'h8000;
        else if (!head_done) rx_status = {1'b1, 1'b0, 3'b000, head_len};
        else                 rx_status = {1'b0, head_err, head_code, head_len};
    end

    assign rx_complete   = head_vis && (!vis_d || pop_d);
    assign flag_stat_ovr = q_full;
    assign flag_byte_ovr = halt;
    assign flag_underrun = fault;
    assign adapter_fail  = fault;

endmodule

// File: rtl/rx_pkt_tracker_chk.sv
module rx_pkt_tracker_chk #(
    parameter int DEPTH      = 8,
    parameter int FIFO_BYTES = 2048,
    parameter int MAX_LEN    = 1514,
    parameter int CNT_W      = 4,
    parameter int OCC_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_reset,
    input logic             mac_start,
    input logic             mac_byte,
    input logic             mac_end,
    input logic             host_discard,
    input logic [15:0]      rx_status,
    input logic             rx_complete,
    input logic             flag_receiving,
    input logic             flag_stat_ovr,
    input logic             flag_underrun,
    input logic [CNT_W-1:0] q_count,
    input logic [OCC_W-1:0] occ
);

    assert_mac_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mac_start, mac_byte, mac_end}));

    assert_recv_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_receiving && mac_end) |=> !flag_receiving);

    assert_queue_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    assert_statovr_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_stat_ovr) |-> ($past(host_discard) || $past(rx_reset)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(FIFO_BYTES));

    assert_empty_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |-> (rx_status == 16'h8000));

    assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_status[10:0] <= 11'(MAX_LEN));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_underrun && !rx_reset) |=> flag_underrun);

    assert_complete_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !rx_status[15]);

endmodule

bind rx_pkt_tracker rx_pkt_tracker_chk #(
    .DEPTH(DEPTH), .FIFO_BYTES(FIFO_BYTES), .MAX_LEN(MAX_LEN),
    .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end),
    .host_discard(host_discard), .rx_status(rx_status),
    .rx_complete(rx_complete), .flag_receiving(flag_receiving),
    .flag_stat_ovr(flag_stat_ovr), .flag_underrun(flag_underrun),
    .q_count(q_count), .occ(occ)
);

// File: tb/rx_pkt_tracker_bench.sv
`timescale 1ns/100ps
module rx_pkt_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_reset = 1'b0;
    logic        mac_start = 1'b0, mac_byte = 1'b0, mac_end = 1'b0;
    logic [2:0]  mac_kind = 3'd0;
    logic        host_rd = 1'b0, host_discard = 1'b0;
    logic [15:0] rx_status;
    logic        rx_complete, flag_receiving, flag_stat_ovr;
    logic        flag_byte_ovr, flag_underrun, adapter_fail;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    rx_pkt_tracker u_rx_pkt_tracker (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end),
        .mac_kind(mac_kind), .host_rd(host_rd), .host_discard(host_discard),
        .rx_status(rx_status), .rx_complete(rx_complete),
        .flag_receiving(flag_receiving), .flag_stat_ovr(flag_stat_ovr),
        .flag_byte_ovr(flag_byte_ovr), .flag_underrun(flag_underrun),
        .adapter_fail(adapter_fail)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, driven at a falling edge
    task automatic drive(input logic s, input logic b, input logic e,
                         input logic [2:0] k, input logic r, input logic d,
                         input logic x);
        mac_start = s; mac_byte = b; mac_end = e; mac_kind = k;
        host_rd = r; host_discard = d; rx_reset = x;
        @(negedge clk);
        mac_start = 1'b0; mac_byte = 1'b0; mac_end = 1'b0; mac_kind = 3'd0;
        host_rd = 1'b0; host_discard = 1'b0; rx_reset = 1'b0;
    endtask

    task automatic expect_pkt(input logic [15:0] w, input string req);
        exp_q.push_back(w);
        tag_q.push_back(req);
    endtask

    task automatic open_bytes(input int n);
        drive(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < n; i++) drive(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic close_pkt(input logic [2:0] k);
        drive(0, 0, 1, k, 0, 0, 0);
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic discard();
        drive(0, 0, 0, 0, 0, 1, 0);
    endtask

    // scoreboard monitor: compare each completion against the queue
    always @(negedge clk) begin
        if (rst_n && rx_complete) begin
            if (exp_q.size() == 0) begin
                check(0, "R10 unexpected completion", {16'h0, rx_status}, 32'h0);
            end else begin
                logic [15:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_status == e, t, {16'h0, rx_status}, {16'h0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 32'h0, 32'h1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state, R1 empty word
        check(rx_status == 16'h8000, "R1 empty word", rx_status, 32'h8000);
        check({flag_receiving, flag_stat_ovr, flag_byte_ovr, flag_underrun,
               adapter_fail, rx_complete} == 6'b0, "R11 flags at reset",
              {flag_receiving, flag_stat_ovr, flag_byte_ovr, flag_underrun,
               adapter_fail, rx_complete}, 32'h0);

        // R1 in progress word, R8 receiving
        open_bytes(3);
        check(rx_status == 16'h8003, "R1 partial word", rx_status, 32'h8003);
        check(flag_receiving == 1'b1, "R8 receiving high", flag_receiving, 1);
        expect_pkt(16'h0003, "R2 good frame");
        close_pkt(3'd0);
        check(flag_receiving == 1'b0, "R8 receiving low", flag_receiving, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        check(rx_complete == 1'b0, "R10 single pulse", rx_complete, 0);
        reads(3);
        check(flag_underrun == 1'b0, "R7 exact read", flag_underrun, 0);
        discard();
        check(rx_status == 16'h8000, "R9 discard pops", rx_status, 32'h8000);

        // R2 / R3 error classes
        open_bytes(10); expect_pkt(16'h100A, "R2 dribble"); close_pkt(3'd1);
        open_bytes(5);  expect_pkt(16'h5805, "R3 runt");    close_pkt(3'd2);
        open_bytes(60); expect_pkt(16'h603C, "R3 align");   close_pkt(3'd3);
        open_bytes(64); expect_pkt(16'h6840, "R3 crc");     close_pkt(3'd4);
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1, 1, 0);
        check(flag_underrun == 1'b0, "R9 read ignored with discard", flag_underrun, 0);
        check(rx_status == 16'h8000, "R9 all popped", rx_status, 32'h8000);

        // R9 ignored discards
        discard();
        check(rx_status == 16'h8000 && !flag_underrun, "R9 empty discard",
              rx_status, 32'h8000);
        open_bytes(2);
        discard();
        check(rx_status == 16'h8002, "R9 incomplete head kept", rx_status, 32'h8002);
        expect_pkt(16'h0002, "R9 kept frame");
        close_pkt(3'd0);
        discard();

        // R4 oversize
        open_bytes(1520);
        expect_pkt(16'h4DEA, "R4 oversize");
        close_pkt(3'd0);
        reads(1514);
        check(flag_underrun == 1'b0, "R4 only 1514 stored", flag_underrun, 0);
        discard();

        // R5 descriptor limit
        for (int i = 0; i < 8; i++) begin
            open_bytes(1); expect_pkt(16'h0001, "R5 queued"); close_pkt(3'd0);
        end
        check(flag_stat_ovr == 1'b1, "R5 flag set", flag_stat_ovr, 1);
        drive(1, 0, 0, 0, 0, 0, 0);
        check(flag_receiving == 1'b0, "R5 start refused", flag_receiving, 0);
        for (int i = 0; i < 5; i++) drive(0, 1, 0, 0, 0, 0, 0);
        close_pkt(3'd4);
        discard();
        check(flag_stat_ovr == 1'b0, "R5 flag clears", flag_stat_ovr, 0);
        for (int i = 0; i < 7; i++) discard();
        check(rx_status == 16'h8000, "R5 refused frame absent", rx_status, 32'h8000);

        // R6 byte overrun
        open_bytes(1500); expect_pkt(16'h05DC, "R6 first frame"); close_pkt(3'd0);
        open_bytes(600);
        check(flag_byte_ovr == 1'b1, "R6 flag set", flag_byte_ovr, 1);
        expect_pkt(16'h4224, "R6 clipped frame");
        close_pkt(3'd0);
        drive(1, 0, 0, 0, 0, 0, 0);
        check(flag_receiving == 1'b0, "R6 start refused", flag_receiving, 0);
        close_pkt(3'd0);
        reads(3);
        check(flag_byte_ovr == 1'b1, "R6 held above margin", flag_byte_ovr, 1);
        reads(1);
        check(flag_byte_ovr == 1'b0, "R6 released", flag_byte_ovr, 0);
        discard(); discard();
        check(rx_status == 16'h8000, "R6 drained", rx_status, 32'h8000);

        // R7 underrun
        open_bytes(2); expect_pkt(16'h0002, "R7 frame"); close_pkt(3'd0);
        reads(2);
        check(flag_underrun == 1'b0, "R7 no early fault", flag_underrun, 0);
        reads(1);
        check(flag_underrun && adapter_fail, "R7 fault set",
              {flag_underrun, adapter_fail}, 32'h3);
        repeat (4) drive(0, 0, 0, 0, 0, 0, 0);
        discard();
        check(flag_underrun && adapter_fail, "R7 fault sticky",
              {flag_underrun, adapter_fail}, 32'h3);

        // R11 receive reset
        open_bytes(3);
        drive(0, 0, 0, 0, 0, 0, 1);
        check({flag_underrun, adapter_fail, flag_receiving, flag_byte_ovr,
               flag_stat_ovr} == 5'b0 && rx_status == 16'h8000,
              "R11 rx_reset clears", rx_status, 32'h8000);
        open_bytes(4); expect_pkt(16'h0004, "R11 after reset"); close_pkt(3'd0);
        discard();
        drive(0, 0, 0, 0, 0, 0, 0);
        check(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule